// File: doc/BRIEF.md
# ADC Window Watchdog Comparator

This block sits beside an analog-to-digital converter and inspects every result the converter delivers. Each result arrives as a one-cycle valid strobe with a raw 12-bit sample and the number of the channel it came from. The block compares the raw sample against a programmable window bounded by a high and a low threshold. A sample strictly above the high bound or strictly below the low bound sets a sticky out-of-window flag. An interrupt enable gates that flag onto an interrupt request line.

Monitoring can cover every channel or be narrowed to one programmed channel. The comparison uses the raw converter value, before any output justification, so the thresholds are written in the same 12-bit scale as the sample. Software programs the block through a small register port with a word address, a write strobe and a combinational read-data return. It clears the flag by writing 1 to the status bit.

Register map (word addresses): 0 = control (bit 0 watchdog enable, bit 1 single-channel select, bit 2 interrupt enable, bits 8 and up = monitored channel number); 1 = high threshold in bits [11:0]; 2 = low threshold in bits [11:0]; 3 = status (bit 0 = out-of-window flag, write 1 to clear).

Top module: `adc_window_wdog`

## Requirements
- R1: After reset, flag_o and irq_o are 0, the control word reads 0, the high threshold reads 0xFFF and the low threshold reads 0x000.
- R2: Writing address 1 sets only the high threshold bits [11:0] and writing address 2 sets only the low threshold bits [11:0]; neither write changes the other threshold.
- R3: With the watchdog enabled, a valid result whose raw 12-bit value is strictly greater than the high threshold or strictly less than the low threshold sets flag_o on the clock edge that samples the strobe; a value equal to either threshold does not set it.
- R4: While control bit 0 (enable) is 0, no result sets the flag.
- R5: With control bit 1 (single-channel) clear, results from every channel are checked; with it set, only results whose channel equals the control channel field (bits 8 and up) are checked.
- R6: Once set, the flag stays 1 while further in-window results arrive.
- R7: Writing address 3 with bit 0 = 1 clears the flag on that edge; writing it with bit 0 = 0 leaves the flag unchanged. Status bit 0 reads back the flag.
- R8: When an out-of-window result and a clearing write land on the same edge, the flag is 1 afterwards.
- R9: irq_o is 1 exactly when the flag is 1 and control bit 2 (interrupt enable) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word address (write and read) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| res_valid_i | input | 1 | Conversion result valid, one cycle per result |
| res_data_i | input | 12 | Raw conversion result |
| res_chan_i | input | 5 | Channel number of the result |
| flag_o | output | 1 | Sticky out-of-window flag |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong threshold register or a wrong comparison operator shows on flag_o one edge after the result strobe that exposes it, which is why every table vector clears the flag, sends one sample and reads the flag on the very next cycle, with samples placed on, just past and far past each bound. A corrupted channel filter shows as a flag from a masked channel or a missing flag from the selected one, again one edge after the strobe. A lost or stuck flag state shows both on flag_o and on irq_o as soon as the interrupt enable is set, and through status bit 0 at once, so clear, sticky and set-over-clear behaviour are each read back the cycle after their stimulus.

// File: rtl/adc_wdog_pkg.sv
package adc_wdog_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned CTRL_EN_BIT  = 0;
  localparam int unsigned CTRL_SGL_BIT = 1;
  localparam int unsigned CTRL_IRQ_BIT = 2;
  localparam int unsigned CTRL_CH_LSB  = 8;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_HIGH = 2'd1,
    ADDR_LOW  = 2'd2,
    ADDR_STAT = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/adc_wdog_regs.sv
module adc_wdog_regs
  import adc_wdog_pkg::*;
#(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned CH_W   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              flag_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              en_o,
  output logic              sgl_o,
  output logic              irq_en_o,
  output logic [CH_W-1:0]   chan_o,
  output logic [DATA_W-1:0] high_o,
  output logic [DATA_W-1:0] low_o,
  output logic              clr_o
);
  localparam logic [DATA_W-1:0] HIGH_RST = '1;
  localparam logic [DATA_W-1:0] LOW_RST  = '0;

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o     <= 1'b0;
      sgl_o    <= 1'b0;
      irq_en_o <= 1'b0;
      chan_o   <= '0;
      high_o   <= HIGH_RST;
      low_o    <= LOW_RST;
    end else if (we_i) begin
      unique case (reg_addr_e'(addr_i))
        ADDR_CTRL: begin
          en_o     <= wdata_i[CTRL_EN_BIT];
          sgl_o    <= wdata_i[CTRL_SGL_BIT];
          irq_en_o <= wdata_i[CTRL_IRQ_BIT];
          chan_o   <= wdata_i[CTRL_CH_LSB +: CH_W];
        end
        ADDR_HIGH: high_o <= wdata_i[DATA_W-1:0];
        ADDR_LOW:  low_o  <= wdata_i[DATA_W-1:0];
        default: ;
      endcase
    end
  end

  assign clr_o = we_i && (reg_addr_e'(addr_i) == ADDR_STAT) && wdata_i[0];

  always_comb begin
    rdata_o = '0;
    unique case (reg_addr_e'(addr_i))
      ADDR_CTRL: begin
        rdata_o[CTRL_EN_BIT]            = en_o;
        rdata_o[CTRL_SGL_BIT]           = sgl_o;
        rdata_o[CTRL_IRQ_BIT]           = irq_en_o;
        rdata_o[CTRL_CH_LSB +: CH_W]    = chan_o;
      end
      ADDR_HIGH: rdata_o[DATA_W-1:0] = high_o;
      ADDR_LOW:  rdata_o[DATA_W-1:0] = low_o;
      default:   rdata_o[0] = flag_i;
    endcase
  end

  // R2: a threshold write leaves the other threshold untouched
  a_r2_high_keeps_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && reg_addr_e'(addr_i) == ADDR_HIGH) |=> $stable(low_o));
  a_r2_low_keeps_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && reg_addr_e'(addr_i) == ADDR_LOW) |=> $stable(high_o));
endmodule

// File: rtl/adc_wdog_cmp.sv
module adc_wdog_cmp #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned CH_W   = 5
) (
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CH_W-1:0]   chan_i,
  input  logic              en_i,
  input  logic              sgl_i,
  input  logic [CH_W-1:0]   sel_chan_i,
  input  logic [DATA_W-1:0] high_i,
  input  logic [DATA_W-1:0] low_i,
  output logic              hit_o
);
  logic chan_ok, above, below;

  assign chan_ok = !sgl_i || (chan_i == sel_chan_i);
  // strict compare: equal to a bound is inside
  assign above   = data_i > high_i;
  assign below   = data_i < low_i;
  assign hit_o   = valid_i && en_i && chan_ok && (above || below);

  // R3: in-window raw values never raise a hit
  always_comb begin
    if (valid_i && data_i <= high_i && data_i >= low_i)
      a_r3_inside_no_hit: assert (!hit_o);
  end
endmodule

// File: rtl/adc_wdog_flag.sv
module adc_wdog_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (hit_i)  flag_o <= 1'b1;  // set beats clear
    else if (clr_i)  flag_o <= 1'b0;
  end

  a_r3_hit_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |=> flag_o);
  a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);
  a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !hit_i) |=> !flag_o);
  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && hit_i) |=> flag_o);
  a_r3_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_o && !hit_i) |=> !flag_o);
endmodule

// File: rtl/adc_window_wdog.sv
module adc_window_wdog
  import adc_wdog_pkg::*;
#(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned CH_W   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              res_valid_i,
  input  logic [DATA_W-1:0] res_data_i,
  input  logic [CH_W-1:0]   res_chan_i,
  output logic              flag_o,
  output logic              irq_o
);
  logic              en, sgl, irq_en, clr, hit;
  logic [CH_W-1:0]   sel_chan;
  logic [DATA_W-1:0] high_thr, low_thr;

  adc_wdog_regs #(.DATA_W(DATA_W), .CH_W(CH_W)) i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .flag_i   (flag_o),
    .rdata_o  (reg_rdata_o),
    .en_o     (en),
    .sgl_o    (sgl),
    .irq_en_o (irq_en),
    .chan_o   (sel_chan),
    .high_o   (high_thr),
    .low_o    (low_thr),
    .clr_o    (clr)
  );

  adc_wdog_cmp #(.DATA_W(DATA_W), .CH_W(CH_W)) i_cmp (
    .valid_i    (res_valid_i),
    .data_i     (res_data_i),
    .chan_i     (res_chan_i),
    .en_i       (en),
    .sgl_i      (sgl),
    .sel_chan_i (sel_chan),
    .high_i     (high_thr),
    .low_i      (low_thr),
    .hit_o      (hit)
  );

  adc_wdog_flag i_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (hit),
    .clr_i  (clr),
    .flag_o (flag_o)
  );

  assign irq_o = flag_o && irq_en;

  a_r4_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !flag_o) |=> !flag_o);
  a_r5_masked_chan_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sgl && res_chan_i != sel_chan && !flag_o) |=> !flag_o);
  a_r9_irq_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag_o);
endmodule

// File: tb/test_adc_window_wdog.sv
module test_adc_window_wdog;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        valid = 1'b0;
  logic [11:0] data = '0;
  logic [4:0]  chan = '0;
  logic        flag, irq;

  int errors = 0;
  int checks = 0;

  // vector: {chan[4:0], data[11:0], expected flag}; window high=0xC00, low=0x100
  localparam logic [NVEC-1:0][17:0] VECS = '{
    {5'd0,  12'hC00, 1'b0},
    {5'd1,  12'hC01, 1'b1},
    {5'd2,  12'h100, 1'b0},
    {5'd3,  12'h0FF, 1'b1},
    {5'd4,  12'h800, 1'b0},
    {5'd17, 12'hFFF, 1'b1},
    {5'd31, 12'h000, 1'b1},
    {5'd9,  12'h101, 1'b0},
    {5'd12, 12'hBFF, 1'b0}
  };

  adc_window_wdog i_adc_window_wdog (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .res_valid_i(valid),
    .res_data_i(data), .res_chan_i(chan), .flag_o(flag), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic rd_check(input string req, input logic [1:0] a, input logic [31:0] exp);
    @(negedge clk); addr = a; #1;
    check(req, rdata, exp);
  endtask

  task automatic send(input logic [4:0] c, input logic [11:0] d);
    @(negedge clk); valid = 1'b1; chan = c; data = d;
    @(negedge clk); valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 flag", {31'd0, flag}, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    rd_check("R1 ctrl", 2'd0, 32'h0);
    rd_check("R1 high", 2'd1, 32'hFFF);
    rd_check("R1 low", 2'd2, 32'h000);
    // R2 independent thresholds
    wr(2'd1, 32'hFFFF_FC00);
    rd_check("R2 high written", 2'd1, 32'hC00);
    rd_check("R2 low kept", 2'd2, 32'h000);
    wr(2'd2, 32'h0000_0100);
    rd_check("R2 low written", 2'd2, 32'h100);
    rd_check("R2 high kept", 2'd1, 32'hC00);
    // R4 disabled: out-of-window samples ignored
    send(5'd1, 12'hFFF);
    check("R4 disabled high", {31'd0, flag}, 32'd0);
    send(5'd1, 12'h000);
    check("R4 disabled low", {31'd0, flag}, 32'd0);
    // enable, all channels
    wr(2'd0, 32'h1);
    rd_check("R1 ctrl readback", 2'd0, 32'h1);
    // R3/R5 table walk
    for (int i = 0; i < NVEC; i++) begin
      wr(2'd3, 32'h1);
      send(VECS[i][17:13], VECS[i][12:1]);
      check($sformatf("R3 vec%0d", i), {31'd0, flag}, {31'd0, VECS[i][0]});
    end
    // R7 status readback and clear semantics
    wr(2'd3, 32'h1);
    send(5'd0, 12'hFFE);
    rd_check("R7 status set", 2'd3, 32'h1);
    wr(2'd3, 32'h0);
    check("R7 write0 keeps", {31'd0, flag}, 32'd1);
    // R6 sticky through in-window
    send(5'd0, 12'h500);
    check("R6 sticky", {31'd0, flag}, 32'd1);
    // R9 irq gating
    check("R9 irq off", {31'd0, irq}, 32'd0);
    wr(2'd0, 32'h5);
    check("R9 irq on", {31'd0, irq}, 32'd1);
    wr(2'd3, 32'h1);
    check("R7 cleared", {31'd0, flag}, 32'd0);
    check("R9 irq follows", {31'd0, irq}, 32'd0);
    rd_check("R7 status clear", 2'd3, 32'h0);
    // R8 set wins over clear
    send(5'd0, 12'hFFF);
    @(negedge clk); we = 1'b1; addr = 2'd3; wdata = 32'h1;
    valid = 1'b1; chan = 5'd2; data = 12'h050;
    @(negedge clk); we = 1'b0; valid = 1'b0; wdata = '0;
    check("R8 set wins", {31'd0, flag}, 32'd1);
    // R5 single-channel select: channel 3, bits 8 and up
    wr(2'd0, 32'h0000_0303);
    rd_check("R5 ctrl readback", 2'd0, 32'h303);
    wr(2'd3, 32'h1);
    send(5'd2, 12'hFFF);
    check("R5 other chan masked", {31'd0, flag}, 32'd0);
    send(5'd19, 12'h000);
    check("R5 aliased chan masked", {31'd0, flag}, 32'd0);
    send(5'd3, 12'hC01);
    check("R5 selected chan", {31'd0, flag}, 32'd1);
    wr(2'd3, 32'h1);
    send(5'd3, 12'hC00);
    check("R3 equal high inside", {31'd0, flag}, 32'd0);
    // R4 disable again after use
    wr(2'd0, 32'h0);
    send(5'd3, 12'hFFF);
    check("R4 re-disabled", {31'd0, flag}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule